// File: doc/BRIEF.md
# Dual Data Address Generator

This block forms memory addresses for a processor core from two banks of index and modify registers. One generator serves data memory and owns index registers 0 to 7 and modify registers 0 to 7, with 32-bit addresses. The other serves program memory and owns registers 8 to 15, with 24-bit addresses. Each generator has its own request channel, so both can issue an address in the same cycle.

A request either accesses memory or only modifies an index register. An access runs in one of two modes. In premodify mode the issued address is index plus modifier and the index register is left alone; indirect branch targets use this mode. In postmodify mode the issued address is the index register itself, and index plus modifier is written back. The modifier is a modify register or a signed 6-bit immediate.

A register port loads and reads any index or modify register of either bank. The issued address appears one clock after the request. Register updates also take effect at that edge.

Top module: `dual_agen`

## Requirements
- R1: After reset every index and modify register reads 0, and both address valid outputs are low.
- R2: A load writes `ld_data` into the register chosen by `ld_num` and `ld_mod`, where `ld_mod` 0 is index and 1 is modify. Bit 3 of `ld_num` selects the bank: 0 is data memory and 1 is program memory. Bits 2:0 select the register within the bank. Reads through `rd_num`/`rd_mod` use the same numbering. A program-memory register keeps only the low 24 bits and reads back zero-extended.
- R3: An access with `upd`=0 (premodify) issues index plus modifier on the address output one cycle later, and the index register keeps its value.
- R4: An access with `upd`=1 (postmodify) issues the old index value one cycle later, and the index register becomes index plus modifier.
- R5: With `imm_en`=1 the modifier is the 6-bit two's-complement `imm` field sign-extended to the address width. With `imm_en`=0 it is the modify register chosen by `mreg`.
- R6: A request with `acc`=0 adds the modifier to the chosen index register whatever `upd` is, and raises no address valid.
- R7: All additions wrap modulo the generator's address width: 2^32 for data memory and 2^24 for program memory.
- R8: The data-memory and program-memory channels operate independently in the same cycle.
- R9: If a load and a postmodify or modify write-back hit the same index register in one cycle, the loaded value is kept. The access still issues the old index value.
- R10: With no request on a channel, its address valid is low the next cycle and its registers are unchanged.
- R11: Back-to-back postmodify requests on one index register see each earlier update, so the issued addresses step by the modifier every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dm_vld | input | 1 | Data-memory channel request |
| dm_acc | input | 1 | 1 = memory access, 0 = modify only |
| dm_upd | input | 1 | 1 = postmodify with update, 0 = premodify |
| dm_imm_en | input | 1 | Use the immediate as modifier |
| dm_ireg | input | 3 | Index register select |
| dm_mreg | input | 3 | Modify register select |
| dm_imm | input | 6 | Signed immediate modifier |
| pm_vld | input | 1 | Program-memory channel request |
| pm_acc | input | 1 | 1 = memory access, 0 = modify only |
| pm_upd | input | 1 | 1 = postmodify with update, 0 = premodify |
| pm_imm_en | input | 1 | Use the immediate as modifier |
| pm_ireg | input | 3 | Index register select (registers 8 to 15) |
| pm_mreg | input | 3 | Modify register select (registers 8 to 15) |
| pm_imm | input | 6 | Signed immediate modifier |
| ld_en | input | 1 | Register load strobe |
| ld_mod | input | 1 | Load target: 0 index, 1 modify |
| ld_num | input | 4 | Load register number 0 to 15 |
| ld_data | input | 32 | Load value |
| rd_mod | input | 1 | Read source: 0 index, 1 modify |
| rd_num | input | 4 | Read register number 0 to 15 |
| rd_data | output | 32 | Read value, zero-extended for the program bank |
| dm_addr | output | 32 | Data-memory address |
| dm_addr_vld | output | 1 | Data-memory address valid |
| pm_addr | output | 24 | Program-memory address |
| pm_addr_vld | output | 1 | Program-memory address valid |

## Verification
Two functions can hit the same index register in one cycle: an explicit register load and the write-back of a postmodify. The bench starts a postmodify access on a data-memory index register and loads that same register in the same cycle. It then checks that the address output carries the pre-load index value and that the register reads back the loaded value, not the incremented sum. Both channels are also driven together in one cycle with different modes. Each result is compared with a shadow register model.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int SEL_W = 3;              // registers per bank = 2**SEL_W
    localparam int NREG  = 1 << SEL_W;
    localparam int IMM_W = 6;              // immediate modifier width

    typedef struct packed {
        logic             vld;
        logic             acc;
        logic             upd;
        logic             imm_en;
        logic [SEL_W-1:0] ireg;
        logic [SEL_W-1:0] mreg;
        logic [IMM_W-1:0] imm;
    } agen_req_t;
endpackage

// File: rtl/agen_unit.sv
module agen_unit
    import agen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  agen_req_t        req,
    input  logic             ld_en,
    input  logic             ld_m,
    input  logic [SEL_W-1:0] ld_idx,
    input  logic [AW-1:0]    ld_data,
    input  logic             rd_m,
    input  logic [SEL_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_data,
    output logic [AW-1:0]    addr_o,
    output logic             addr_vld_o
);
    typedef struct packed {
        logic [NREG-1:0][AW-1:0] ir;
        logic [NREG-1:0][AW-1:0] mr;
        logic [AW-1:0]           addr;
        logic                    avld;
    } state_t;

    state_t        st_d, st_q;
    logic [AW-1:0] mod_d;
    logic [AW-1:0] sum_d;

    always_comb begin
        st_d  = st_q;
        mod_d = req.imm_en ? AW'($signed(req.imm)) : st_q.mr[req.mreg];
        sum_d = st_q.ir[req.ireg] + mod_d;
        st_d.avld = 1'b0;
        if (req.vld) begin
            if (req.acc) begin
                st_d.avld = 1'b1;
                st_d.addr = req.upd ? st_q.ir[req.ireg] : sum_d;
                if (req.upd) st_d.ir[req.ireg] = sum_d;
            end else begin
                st_d.ir[req.ireg] = sum_d;
            end
        end
        // explicit load overrides any write-back to the same register
        if (ld_en) begin
            if (ld_m) st_d.mr[ld_idx] = ld_data;
            else      st_d.ir[ld_idx] = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = rd_m ? st_q.mr[rd_idx] : st_q.ir[rd_idx];
    assign addr_o     = st_q.addr;
    assign addr_vld_o = st_q.avld;

    // R3: premodify leaves the index register untouched
    p_pre_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req.vld && req.acc && !req.upd && !(ld_en && !ld_m && ld_idx == req.ireg))
        |=> st_q.ir[$past(req.ireg)] == $past(st_q.ir[req.ireg]));

    // R4: postmodify issues the old index value
    p_post_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req.vld && req.acc && req.upd)
        |=> (addr_vld_o && addr_o == $past(st_q.ir[req.ireg])));

    // R6: modify-only raises no address
    p_modonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req.vld && !req.acc) |=> !addr_vld_o);

    // R9: load wins over write-back
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !ld_m) |=> st_q.ir[$past(ld_idx)] == $past(ld_data));

    // R10: idle channel issues nothing
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req.vld |=> !addr_vld_o);
endmodule

// File: rtl/dual_agen.sv
module dual_agen
    import agen_pkg::*;
#(
    parameter int DM_AW = 32,
    parameter int PM_AW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dm_vld,
    input  logic             dm_acc,
    input  logic             dm_upd,
    input  logic             dm_imm_en,
    input  logic [SEL_W-1:0] dm_ireg,
    input  logic [SEL_W-1:0] dm_mreg,
    input  logic [IMM_W-1:0] dm_imm,
    input  logic             pm_vld,
    input  logic             pm_acc,
    input  logic             pm_upd,
    input  logic             pm_imm_en,
    input  logic [SEL_W-1:0] pm_ireg,
    input  logic [SEL_W-1:0] pm_mreg,
    input  logic [IMM_W-1:0] pm_imm,
    input  logic             ld_en,
    input  logic             ld_mod,
    input  logic [SEL_W:0]   ld_num,
    input  logic [DM_AW-1:0] ld_data,
    input  logic             rd_mod,
    input  logic [SEL_W:0]   rd_num,
    output logic [DM_AW-1:0] rd_data,
    output logic [DM_AW-1:0] dm_addr,
    output logic             dm_addr_vld,
    output logic [PM_AW-1:0] pm_addr,
    output logic             pm_addr_vld
);
    localparam int BANK_BIT = SEL_W;   // register-number bit that picks the bank

    agen_req_t        dm_req, pm_req;
    logic [DM_AW-1:0] dm_rd;
    logic [PM_AW-1:0] pm_rd;

    assign dm_req = '{vld: dm_vld, acc: dm_acc, upd: dm_upd, imm_en: dm_imm_en,
                      ireg: dm_ireg, mreg: dm_mreg, imm: dm_imm};
    assign pm_req = '{vld: pm_vld, acc: pm_acc, upd: pm_upd, imm_en: pm_imm_en,
                      ireg: pm_ireg, mreg: pm_mreg, imm: pm_imm};

    agen_unit #(.AW(DM_AW)) i_dm_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (dm_req),
        .ld_en      (ld_en && !ld_num[BANK_BIT]),
        .ld_m       (ld_mod),
        .ld_idx     (ld_num[SEL_W-1:0]),
        .ld_data    (ld_data),
        .rd_m       (rd_mod),
        .rd_idx     (rd_num[SEL_W-1:0]),
        .rd_data    (dm_rd),
        .addr_o     (dm_addr),
        .addr_vld_o (dm_addr_vld)
    );

    agen_unit #(.AW(PM_AW)) i_pm_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (pm_req),
        .ld_en      (ld_en && ld_num[BANK_BIT]),
        .ld_m       (ld_mod),
        .ld_idx     (ld_num[SEL_W-1:0]),
        .ld_data    (ld_data[PM_AW-1:0]),
        .rd_m       (rd_mod),
        .rd_idx     (rd_num[SEL_W-1:0]),
        .rd_data    (pm_rd),
        .addr_o     (pm_addr),
        .addr_vld_o (pm_addr_vld)
    );

    assign rd_data = rd_num[BANK_BIT] ? DM_AW'(pm_rd) : dm_rd;
endmodule

// File: tb/test_dual_agen.sv
module test_dual_agen;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // per-channel request state, index 0 = data memory, 1 = program memory
    logic       b_vld [2];
    logic       b_acc [2];
    logic       b_upd [2];
    logic       b_ie  [2];
    logic [2:0] b_ir  [2];
    logic [2:0] b_mr  [2];
    logic [5:0] b_imm [2];
    logic        ld_en, ld_mod, rd_mod;
    logic [3:0]  ld_num, rd_num;
    logic [31:0] ld_data;
    logic [31:0] rd_data, dm_addr;
    logic [23:0] pm_addr;
    logic        dm_addr_vld, pm_addr_vld;

    dual_agen i_dual_agen (
        .clk(clk), .rst_n(rst_n),
        .dm_vld(b_vld[0]), .dm_acc(b_acc[0]), .dm_upd(b_upd[0]), .dm_imm_en(b_ie[0]),
        .dm_ireg(b_ir[0]), .dm_mreg(b_mr[0]), .dm_imm(b_imm[0]),
        .pm_vld(b_vld[1]), .pm_acc(b_acc[1]), .pm_upd(b_upd[1]), .pm_imm_en(b_ie[1]),
        .pm_ireg(b_ir[1]), .pm_mreg(b_mr[1]), .pm_imm(b_imm[1]),
        .ld_en(ld_en), .ld_mod(ld_mod), .ld_num(ld_num), .ld_data(ld_data),
        .rd_mod(rd_mod), .rd_num(rd_num), .rd_data(rd_data),
        .dm_addr(dm_addr), .dm_addr_vld(dm_addr_vld),
        .pm_addr(pm_addr), .pm_addr_vld(pm_addr_vld)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] sh_i [16];
    logic [31:0] sh_m [16];

    function automatic logic [31:0] bank_mask(int g);
        return (g == 1) ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        for (int g = 0; g < 2; g++) begin
            b_vld[g] = 0; b_acc[g] = 0; b_upd[g] = 0; b_ie[g] = 0;
            b_ir[g] = 0; b_mr[g] = 0; b_imm[g] = 0;
        end
        ld_en = 0; ld_mod = 0; ld_num = 0; ld_data = 0;
    endtask

    task automatic set_req(int g, logic acc, logic upd, logic ie,
                           logic [2:0] ir, logic [2:0] mr, logic [5:0] imm);
        b_vld[g] = 1; b_acc[g] = acc; b_upd[g] = upd; b_ie[g] = ie;
        b_ir[g] = ir; b_mr[g] = mr; b_imm[g] = imm;
    endtask

    // inputs already driven after a falling edge; model, clock, check
    task automatic run_cycle(string tag);
        logic        ev [2];
        logic [31:0] ea [2];
        logic [31:0] ni [2];
        logic        wr [2];
        for (int g = 0; g < 2; g++) begin
            int bi = g * 8 + int'(b_ir[g]);
            logic [31:0] mv = b_ie[g] ? {{26{b_imm[g][5]}}, b_imm[g]} : sh_m[g * 8 + int'(b_mr[g])];
            logic [31:0] s  = (sh_i[bi] + mv) & bank_mask(g);
            ev[g] = b_vld[g] && b_acc[g];
            ea[g] = b_upd[g] ? sh_i[bi] : s;
            wr[g] = b_vld[g] && (!b_acc[g] || b_upd[g]);
            ni[g] = s;
        end
        @(posedge clk);
        #1;
        chk({tag, " dm valid"}, {31'b0, dm_addr_vld}, {31'b0, ev[0]});
        chk({tag, " pm valid"}, {31'b0, pm_addr_vld}, {31'b0, ev[1]});
        if (ev[0]) chk({tag, " dm addr"}, dm_addr, ea[0]);
        if (ev[1]) chk({tag, " pm addr"}, {8'b0, pm_addr}, ea[1]);
        for (int g = 0; g < 2; g++)
            if (wr[g]) sh_i[g * 8 + int'(b_ir[g])] = ni[g];
        if (ld_en) begin
            if (ld_mod) sh_m[ld_num] = ld_data & bank_mask(int'(ld_num[3]));
            else        sh_i[ld_num] = ld_data & bank_mask(int'(ld_num[3]));
        end
        clear_req();
    endtask

    task automatic load(logic m, logic [3:0] num, logic [31:0] val);
        @(negedge clk);
        ld_en = 1; ld_mod = m; ld_num = num; ld_data = val;
        run_cycle("load");
    endtask

    task automatic rd_chk(string tag, logic m, logic [3:0] num);
        @(negedge clk);
        rd_mod = m; rd_num = num;
        #1;
        chk({tag, " read"}, rd_data, m ? sh_m[num] : sh_i[num]);
    endtask

    task automatic t_reset();
        for (int r = 0; r < 16; r++) begin
            rd_chk("R1 index", 0, 4'(r));
            rd_chk("R1 modify", 1, 4'(r));
        end
        chk("R1 dm valid", {31'b0, dm_addr_vld}, 0);
        chk("R1 pm valid", {31'b0, pm_addr_vld}, 0);
    endtask

    task automatic t_load_read();
        load(0, 4'd3, 32'h1234_5678);
        load(1, 4'd5, 32'h0000_0010);
        load(0, 4'd9, 32'hFFAB_CDEF);
        load(1, 4'd12, 32'hDEAD_0004);
        rd_chk("R2 dm I3", 0, 4'd3);
        rd_chk("R2 dm M5", 1, 4'd5);
        rd_chk("R2 pm I9", 0, 4'd9);
        chk("R2 pm truncate", rd_data, 32'h00AB_CDEF);
        rd_chk("R2 pm M12", 1, 4'd12);
        rd_chk("R2 dm I1 untouched", 0, 4'd1);
    endtask

    task automatic t_premod();
        @(negedge clk); set_req(0, 1, 0, 0, 3'd3, 3'd5, 0); run_cycle("R3 dm pre");
        rd_chk("R3 dm I3 kept", 0, 4'd3);
        chk("R3 I3 value", rd_data, 32'h1234_5678);
        @(negedge clk); set_req(1, 1, 0, 0, 3'd1, 3'd4, 0); run_cycle("R3 pm pre");
        rd_chk("R3 pm I9 kept", 0, 4'd9);
    endtask

    task automatic t_postmod();
        @(negedge clk); set_req(0, 1, 1, 0, 3'd3, 3'd5, 0); run_cycle("R4 dm post");
        rd_chk("R4 dm I3 updated", 0, 4'd3);
        chk("R4 I3 value", rd_data, 32'h1234_5688);
        @(negedge clk); set_req(1, 1, 1, 0, 3'd1, 3'd4, 0); run_cycle("R4 pm post");
        rd_chk("R4 pm I9 updated", 0, 4'd9);
    endtask

    task automatic t_imm();
        load(0, 4'd0, 32'h0000_0100);
        @(negedge clk); set_req(0, 1, 1, 1, 3'd0, 3'd5, 6'h3F); run_cycle("R5 imm -1");
        rd_chk("R5 I0 after -1", 0, 4'd0);
        chk("R5 I0 value", rd_data, 32'h0000_00FF);
        @(negedge clk); set_req(0, 1, 0, 1, 3'd0, 3'd0, 6'h20); run_cycle("R5 imm -32");
        @(negedge clk); set_req(0, 1, 0, 1, 3'd0, 3'd0, 6'h1F); run_cycle("R5 imm +31");
        chk("R5 +31 addr", dm_addr, 32'h0000_011E);
    endtask

    task automatic t_modonly();
        @(negedge clk); set_req(0, 0, 0, 0, 3'd3, 3'd5, 0); run_cycle("R6 modify upd0");
        rd_chk("R6 I3", 0, 4'd3);
        @(negedge clk); set_req(1, 0, 1, 1, 3'd4, 3'd0, 6'h02); run_cycle("R6 modify upd1");
        rd_chk("R6 I12", 0, 4'd12);
        chk("R6 I12 value", rd_data, 32'h0000_0002);
    endtask

    task automatic t_wrap();
        load(0, 4'd7, 32'hFFFF_FFFF);
        load(1, 4'd7, 32'h0000_0002);
        @(negedge clk); set_req(0, 1, 1, 0, 3'd7, 3'd7, 0); run_cycle("R7 dm wrap");
        rd_chk("R7 dm I7", 0, 4'd7);
        chk("R7 dm wrap value", rd_data, 32'h0000_0001);
        load(0, 4'd15, 32'h00FF_FFFF);
        @(negedge clk); set_req(1, 1, 0, 1, 3'd7, 3'd0, 6'h01); run_cycle("R7 pm wrap");
        chk("R7 pm wrap addr", {8'b0, pm_addr}, 32'h0);
    endtask

    task automatic t_parallel();
        @(negedge clk);
        set_req(0, 1, 1, 1, 3'd3, 3'd0, 6'h08);
        set_req(1, 1, 0, 0, 3'd1, 3'd4, 0);
        run_cycle("R8 both");
        rd_chk("R8 dm I3", 0, 4'd3);
        rd_chk("R8 pm I9", 0, 4'd9);
    endtask

    task automatic t_load_wins();
        load(0, 4'd2, 32'h0000_0040);
        load(1, 4'd2, 32'h0000_0004);
        @(negedge clk);
        set_req(0, 1, 1, 0, 3'd2, 3'd2, 0);
        ld_en = 1; ld_mod = 0; ld_num = 4'd2; ld_data = 32'hCAFE_0000;
        run_cycle("R9 clash");
        chk("R9 addr old I", dm_addr, 32'h0000_0040);
        rd_chk("R9 I2 loaded", 0, 4'd2);
        chk("R9 I2 value", rd_data, 32'hCAFE_0000);
    endtask

    task automatic t_idle();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); run_cycle("R10 idle");
        end
        rd_chk("R10 I3 held", 0, 4'd3);
        rd_chk("R10 I9 held", 0, 4'd9);
    endtask

    task automatic t_chain();
        load(1, 4'd11, 32'h0000_0010);
        load(0, 4'd13, 32'h0000_1000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); set_req(1, 1, 1, 0, 3'd5, 3'd3, 0); run_cycle("R11 chain");
            chk("R11 step addr", {8'b0, pm_addr}, 32'h0000_1000 + 32'(k) * 32'h10);
        end
        rd_chk("R11 I13 final", 0, 4'd13);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++) begin sh_i[r] = 0; sh_m[r] = 0; end
        clear_req();
        rd_mod = 0; rd_num = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_load_read();
        t_premod();
        t_postmod();
        t_imm();
        t_modonly();
        t_wrap();
        t_parallel();
        t_load_wins();
        t_idle();
        t_chain();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule